// File: doc/BRIEF.md
# Two-Pass Fixed-Point 8x8 Inverse Transform Engine

This block turns an 8x8 block of signed 12-bit transform coefficients into 64 signed 10-bit spatial samples. It computes the transform as two matrix passes, one after the other. Each pass has its own multiply-accumulate unit. The unit multiplies a data value by one entry of a 64-entry scale table that software loads. Both passes drop low product bits at fixed points and let a 17-bit accumulator wrap, so the result depends exactly on where the bits are cut.

Pass 1 works through the block one column at a time. Each column it finishes goes into a 16-entry ping-pong store. Pass 2 reads one half of that store while pass 1 fills the other half. Because of this overlap, a whole block takes nine column periods rather than sixteen. Load the table while the engine is idle. Then hand the engine a complete coefficient block with a valid/ready handshake, and collect the samples as a stream, with a pulse that marks the last sample.

Top module: `idct_2pass`

## Requirements
- R1: A table write with `tab_we` high stores bits 15..3 of `tab_wdata` as a signed 13-bit entry at `tab_addr`. Bits 2..0 of the word have no effect on any output.
- R2: After reset, `in_ready` is high and `out_valid` and `done` are low. A block is captured on a clock edge where `in_valid` and `in_ready` are both high. Coefficient k is the two's-complement field `in_coefs[12k+11:12k]`. `in_ready` then stays low until the block completes, and `in_valid` or `in_coefs` activity while busy has no effect on the output.
- R3: Pass 1 computes each term as bits 23..7 of the signed product coefficient x table entry, a 17-bit value. It sums eight such terms modulo 2^17 and keeps bits 16..4 of the sum as a signed 13-bit intermediate.
- R4: Intermediate element (x,y) is the sum over z of coefficient[y+8z] x table[x+8z], with x the column (0..7) and y the row (0..7).
- R5: Pass 2 multiplies intermediate[y+8z] by bits 12..1 of table[x+8z], a signed 12-bit value. It truncates and wraps the same way as pass 1, and output sample x+8y is bits 16..7 of the sum.
- R6: The 64 samples appear in ascending index order 0..63, one per single-cycle `out_valid` pulse, with consecutive pulses exactly 8 cycles apart.
- R7: `done` is high in the same cycle as the 64th sample, 576 cycles after the accepting edge. `in_ready` is high in the following cycle.
- R8: The first sample of a block is visible 72 cycles after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tab_we | input | 1 | Scale table write strobe |
| tab_addr | input | 6 | Scale table entry index |
| tab_wdata | input | 16 | Table word; the upper 13 bits are kept |
| in_valid | input | 1 | Coefficient block offered |
| in_ready | output | 1 | Engine idle and able to take a block |
| in_coefs | input | 768 | 64 packed signed 12-bit coefficients |
| out_valid | output | 1 | Output sample valid |
| out_sample | output | 10 | Signed 10-bit output sample |
| done | output | 1 | Pulse with the last sample of a block |

## Verification
The assertions check the following on every cycle:
- the handshake and sequencing rules, namely the idle state after reset, `in_ready` dropping after a capture, `in_ready` staying low while samples stream out, and a gap after every sample pulse;
- that `done` falls exactly on the 64th sample since the capture, and that `in_ready` returns right after it.

Only the bench scenarios can show the following:
- the arithmetic, namely where each pass cuts bits, the 17-bit wrap, the single dropped table bit in pass 2, the column-wise indexing, and the raster output order;
- that ignored inputs (low table bits, offers made while busy) leave the samples unchanged;
- the exact 72- and 576-cycle latencies.

The bench compares every sample with a model that it builds from the arithmetic rules in R3 to R5.

// File: rtl/idct_pkg.sv
package idct_pkg;
    localparam int N       = 8;
    localparam int NE      = N * N;
    localparam int IDX_W   = $clog2(NE);
    localparam int LANE_W  = $clog2(N);
    localparam int COEF_W  = 12;
    localparam int TAB_W   = 13;
    localparam int WORD_W  = 16;
    localparam int ACC_W   = 17;
    localparam int MID_W   = 13;
    localparam int OUT_W   = 10;
    localparam int DROP_W  = 7;
    localparam int T2_W    = TAB_W - 1;
    localparam int RUN_CYC = (N + 1) * N * N;
    localparam int CNT_W   = $clog2(RUN_CYC + 1);
    localparam int PH_W    = CNT_W - 2 * LANE_W;
    localparam int MID_AW  = LANE_W + 1;

    typedef logic [COEF_W-1:0] coef_t;
    typedef logic [TAB_W-1:0]  tab_t;
    typedef logic [ACC_W-1:0]  acc_t;
    typedef logic [MID_W-1:0]  mid_t;

    typedef enum logic {ST_IDLE, ST_RUN} eng_state_t;

    typedef struct packed {
        logic en;
        logic first;
        logic last;
    } mac_ctl_t;

    function automatic mac_ctl_t tap_ctl(input logic en, input logic [LANE_W-1:0] z);
        mac_ctl_t c;
        c.en    = en;
        c.first = (z == '0);
        c.last  = (z == LANE_W'(N - 1));
        return c;
    endfunction
endpackage

// File: rtl/idct_booth_mul.sv
module idct_booth_mul #(
    parameter int A_W = 12,
    parameter int B_W = 13
) (
    input  logic [A_W-1:0]     a,
    input  logic [B_W-1:0]     b,
    output logic [A_W+B_W-1:0] p
);
    localparam int P_W = A_W + B_W;
    localparam int NPP = A_W / 2;

    function automatic logic [P_W-1:0] booth_pp(input logic [2:0] t, input logic [P_W-1:0] bx);
        case (t)
            3'b001, 3'b010: return bx;
            3'b011:         return bx << 1;
            3'b100:         return -(bx << 1);
            3'b101, 3'b110: return -bx;
            default:        return '0;
        endcase
    endfunction

    logic [P_W-1:0]          bext;
    logic [NPP-1:0][P_W-1:0] pp;
    logic [P_W-1:0]          p_sum;

    assign bext = {{(P_W - B_W){b[B_W-1]}}, b};

    for (genvar i = 0; i < NPP; i++) begin : g_pp
        logic [2:0] trip;
        if (i == 0) begin : g_lo
            assign trip = {a[1], a[0], 1'b0};
        end else begin : g_hi
            assign trip = a[2*i+1 -: 3];
        end
        assign pp[i] = booth_pp(trip, bext) << (2 * i);
    end

    always_comb begin
        p_sum = '0;
        for (int i = 0; i < NPP; i++) p_sum = p_sum + pp[i];
    end

    assign p = p_sum;
endmodule

// File: rtl/idct_mac.sv
module idct_mac
    import idct_pkg::*;
#(
    parameter int A_W = 12,
    parameter int B_W = 13
) (
    input  logic           clk,
    input  logic           rst,
    input  mac_ctl_t       ctl,
    input  logic [A_W-1:0] a,
    input  logic [B_W-1:0] b,
    output acc_t           acc,
    output logic           sum_valid
);
    logic [A_W+B_W-1:0] prod;
    acc_t               term;

    idct_booth_mul #(.A_W(A_W), .B_W(B_W)) u_mul (.a(a), .b(b), .p(prod));

    assign term = prod[DROP_W +: ACC_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            acc       <= '0;
            sum_valid <= 1'b0;
        end else begin
            sum_valid <= ctl.en & ctl.last;
            if (ctl.en) acc <= (ctl.first ? acc_t'(0) : acc) + term;
        end
    end
endmodule

// File: rtl/idct_scale_table.sv
module idct_scale_table
    import idct_pkg::*;
#(
    parameter int NRD = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic [IDX_W-1:0]          waddr,
    input  logic [WORD_W-1:0]         wdata,
    input  logic [NRD-1:0][IDX_W-1:0] raddr,
    output logic [NRD-1:0][TAB_W-1:0] rdata
);
    localparam int ROWS = NE / 2;

    logic [ROWS-1:0][2*TAB_W-1:0] mem;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem <= '0;
        end else if (we) begin
            if (waddr[0]) mem[waddr[IDX_W-1:1]][TAB_W +: TAB_W] <= wdata[WORD_W-1 -: TAB_W];
            else          mem[waddr[IDX_W-1:1]][0 +: TAB_W]     <= wdata[WORD_W-1 -: TAB_W];
        end
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign rdata[r] = raddr[r][0] ? mem[raddr[r][IDX_W-1:1]][TAB_W +: TAB_W]
                                      : mem[raddr[r][IDX_W-1:1]][0 +: TAB_W];
    end
endmodule

// File: rtl/idct_2pass.sv
module idct_2pass
    import idct_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tab_we,
    input  logic [IDX_W-1:0]      tab_addr,
    input  logic [WORD_W-1:0]     tab_wdata,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [NE*COEF_W-1:0]  in_coefs,
    output logic                  out_valid,
    output logic [OUT_W-1:0]      out_sample,
    output logic                  done
);
    eng_state_t              st;
    logic [CNT_W-1:0]        cnt;
    logic [NE-1:0][COEF_W-1:0] coef_q;
    logic [2*N-1:0][MID_W-1:0] mid_q;
    logic [MID_AW-1:0]       wtag_q;

    logic [PH_W-1:0]   phase;
    logic [LANE_W-1:0] lane, tap;
    logic              run, accept, p1_en, p2_en;
    mac_ctl_t          ctl1, ctl2;

    logic [1:0][IDX_W-1:0] tab_ra;
    logic [1:0][TAB_W-1:0] tab_rd;

    coef_t p1_a;
    mid_t  p2_b;
    acc_t  acc1, acc2;
    logic  v1, v2;

    // ---- sequencing: one counter covers nine column periods ----
    assign accept = in_valid && (st == ST_IDLE);
    assign run    = (st == ST_RUN);
    assign phase  = cnt[CNT_W-1 -: PH_W];
    assign lane   = cnt[LANE_W +: LANE_W];
    assign tap    = cnt[0 +: LANE_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            coef_q <= '0;
        end else begin
            case (st)
                ST_IDLE: if (accept) begin
                    st     <= ST_RUN;
                    cnt    <= '0;
                    coef_q <= in_coefs;
                end
                default: if (cnt == CNT_W'(RUN_CYC)) st <= ST_IDLE;
                         else cnt <= cnt + 1'b1;
            endcase
        end
    end

    assign p1_en = run && (phase < PH_W'(N));
    assign p2_en = run && (phase != '0) && (cnt < CNT_W'(RUN_CYC));
    assign ctl1  = tap_ctl(p1_en, tap);
    assign ctl2  = tap_ctl(p2_en, tap);

    // ---- scale table: pass 1 column = phase, pass 2 column = lane ----
    assign tab_ra[0] = {tap, phase[LANE_W-1:0]};
    assign tab_ra[1] = {tap, lane};

    idct_scale_table #(.NRD(2)) u_tab (
        .clk(clk), .rst(rst),
        .we(tab_we), .waddr(tab_addr), .wdata(tab_wdata),
        .raddr(tab_ra), .rdata(tab_rd)
    );

    // ---- pass 1: coefficient[y+8z] x table[x+8z] ----
    assign p1_a = coef_q[{tap, lane}];

    idct_mac #(.A_W(COEF_W), .B_W(TAB_W)) u_mac1 (
        .clk(clk), .rst(rst), .ctl(ctl1),
        .a(p1_a), .b(tab_rd[0]),
        .acc(acc1), .sum_valid(v1)
    );

    // ---- ping-pong intermediate store: half = column parity ----
    always_ff @(posedge clk) begin
        if (rst) begin
            mid_q  <= '0;
            wtag_q <= '0;
        end else begin
            if (p1_en) wtag_q <= {phase[0], lane};
            if (v1)    mid_q[wtag_q] <= acc1[ACC_W-1 -: MID_W];
        end
    end

    // ---- pass 2: intermediate[y+8z] x table[x+8z] (upper 12 bits) ----
    assign p2_b = mid_q[{~phase[0], tap}];

    idct_mac #(.A_W(T2_W), .B_W(MID_W)) u_mac2 (
        .clk(clk), .rst(rst), .ctl(ctl2),
        .a(tab_rd[1][TAB_W-1:1]), .b(p2_b),
        .acc(acc2), .sum_valid(v2)
    );

    assign in_ready   = (st == ST_IDLE);
    assign out_valid  = v2;
    assign out_sample = acc2[ACC_W-1 -: OUT_W];
    assign done       = v2 && (cnt == CNT_W'(RUN_CYC));
endmodule

// File: rtl/idct_2pass_chk.sv
module idct_2pass_chk (
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic in_ready,
    input logic out_valid,
    input logic done
);
    logic [6:0] nout;

    always_ff @(posedge clk) begin
        if (rst)                        nout <= '0;
        else if (in_valid && in_ready)  nout <= '0;
        else if (out_valid)             nout <= nout + 1'b1;
    end

    assert_reset_idle_R2: assert property (@(posedge clk)
        rst |=> (in_ready && !out_valid && !done));

    assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    assert_no_sample_when_idle_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    assert_sample_gap_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    assert_done_on_last_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> (out_valid && nout == 7'd63));

    assert_ready_after_done_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> in_ready);
endmodule

bind idct_2pass idct_2pass_chk u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .done(done)
);

// File: tb/sim_idct_2pass.sv
module sim_idct_2pass;
    import idct_pkg::*;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 tab_we = 1'b0;
    logic [IDX_W-1:0]     tab_addr = '0;
    logic [WORD_W-1:0]    tab_wdata = '0;
    logic                 in_valid = 1'b0;
    logic                 in_ready;
    logic [NE*COEF_W-1:0] in_coefs = '0;
    logic                 out_valid;
    logic [OUT_W-1:0]     out_sample;
    logic                 done;

    always #2 clk = ~clk;

    idct_2pass u0 (
        .clk(clk), .rst(rst), .tab_we(tab_we), .tab_addr(tab_addr), .tab_wdata(tab_wdata),
        .in_valid(in_valid), .in_ready(in_ready), .in_coefs(in_coefs),
        .out_valid(out_valid), .out_sample(out_sample), .done(done)
    );

    typedef struct {
        int    val;
        string tag;
    } exp_t;

    exp_t sbq[$];
    int   errors = 0, checks = 0;
    int   ecnt = 0;
    int   acc_edge = 0, last_out = 0, nout_blk = 0;
    bit   chk_ready = 0;
    int   coef_v[64];
    int   word_v[64];

    always @(posedge clk) ecnt <= ecnt + 1;

    function automatic int sx(input int v, input int w);
        return (v <<< (32 - w)) >>> (32 - w);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // reference built from R3, R4, R5
    task automatic push_expect(input string tag);
        int ent[64];
        int mid[64];
        int acc, term;
        longint p;
        for (int k = 0; k < 64; k++) ent[k] = sx(word_v[k] >> 3, 13);
        for (int x = 0; x < 8; x++)
            for (int y = 0; y < 8; y++) begin
                acc = 0;
                for (int z = 0; z < 8; z++) begin
                    p    = longint'(coef_v[y + 8*z]) * longint'(ent[x + 8*z]);
                    term = sx(int'((p >>> 7) & 64'h1FFFF), 17);
                    acc  = sx(acc + term, 17);
                end
                mid[x + 8*y] = acc >>> 4;
            end
        for (int y = 0; y < 8; y++)
            for (int x = 0; x < 8; x++) begin
                exp_t e;
                acc = 0;
                for (int z = 0; z < 8; z++) begin
                    p    = longint'(mid[y + 8*z]) * longint'(ent[x + 8*z] >>> 1);
                    term = sx(int'((p >>> 7) & 64'h1FFFF), 17);
                    acc  = sx(acc + term, 17);
                end
                e.val = acc >>> 7;
                e.tag = tag;
                sbq.push_back(e);
            end
    endtask

    task automatic load_table();
        for (int k = 0; k < 64; k++) begin
            @(negedge clk);
            tab_we    = 1'b1;
            tab_addr  = IDX_W'(k);
            tab_wdata = WORD_W'(word_v[k]);
        end
        @(negedge clk);
        tab_we = 1'b0;
    endtask

    task automatic send_block(input string tag);
        @(negedge clk);
        for (int k = 0; k < 64; k++) in_coefs[k*COEF_W +: COEF_W] = COEF_W'(coef_v[k]);
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        push_expect(tag);
        acc_edge = ecnt + 1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (sbq.size() != 0 || !in_ready) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (chk_ready) begin
                check(in_ready == 1'b1, "R7", int'(in_ready), 1, "in_ready after done");
                chk_ready = 0;
            end
            if (out_valid) begin
                if (sbq.size() == 0) begin
                    check(1'b0, "R6", 1, 0, "sample with empty scoreboard");
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    check(int'($signed(out_sample)) == e.val, e.tag,
                          int'($signed(out_sample)), e.val, "sample value");
                end
                if (nout_blk == 0)
                    check(ecnt - acc_edge == 72, "R8", ecnt - acc_edge, 72, "first sample latency");
                else
                    check(ecnt - last_out == 8, "R6", ecnt - last_out, 8, "sample spacing");
                last_out = ecnt;
                nout_blk++;
            end
            if (done) begin
                check(ecnt - acc_edge == 576, "R7", ecnt - acc_edge, 576, "done latency");
                check(nout_blk == 64, "R7", nout_blk, 64, "samples before done");
                nout_blk  = 0;
                chk_ready = 1;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(in_ready == 1'b1, "R2", int'(in_ready), 1, "in_ready after reset");
        check(out_valid == 1'b0, "R2", int'(out_valid), 0, "out_valid after reset");
        check(done == 1'b0, "R2", int'(done), 0, "done after reset");

        // single DC coefficient, flat table
        for (int k = 0; k < 64; k++) begin coef_v[k] = 0; word_v[k] = 16'h4000; end
        coef_v[0] = 640;
        load_table();
        send_block("R5");
        wait_idle();

        // asymmetric data exposes the column-wise index order
        for (int k = 0; k < 64; k++) begin
            coef_v[k] = sx(int'($urandom) & 12'hFFF, 12);
            word_v[k] = int'($urandom) & 16'hFFF8;
        end
        load_table();
        send_block("R4");
        wait_idle();

        // extreme magnitudes drive the 17-bit wrap
        for (int k = 0; k < 64; k++) begin
            coef_v[k] = ((k % 3) == 0) ? -2048 : (((k % 3) == 1) ? 2047 : 1900 - k);
            word_v[k] = ((k % 2) == 0) ? 16'h8000 : 16'h7FF8;
        end
        load_table();
        send_block("R3");
        wait_idle();

        // table words with junk in the dropped low bits
        for (int k = 0; k < 64; k++) begin
            coef_v[k] = sx(int'($urandom) & 12'hFFF, 12);
            word_v[k] = int'($urandom) & 16'hFFFF;
        end
        load_table();
        send_block("R1");
        wait_idle();

        // offers while busy must be ignored
        for (int k = 0; k < 64; k++) coef_v[k] = sx(int'($urandom) & 12'hFFF, 12);
        send_block("R2");
        repeat (20) @(negedge clk);
        in_valid = 1'b1;
        for (int k = 0; k < 64; k++) in_coefs[k*COEF_W +: COEF_W] = COEF_W'($urandom);
        repeat (100) begin
            @(negedge clk);
            if (in_ready) check(1'b0, "R2", 1, 0, "in_ready while busy");
        end
        in_valid = 1'b0;

        // back-to-back block queued while the previous one runs
        for (int k = 0; k < 64; k++) coef_v[k] = sx(int'($urandom) & 12'hFFF, 12);
        send_block("R7");
        wait_idle();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule